// File: doc/BRIEF.md
# Compensated Seconds Prescaler

This block turns a free-running 32 kHz oscillator clock into a one-second update pulse. It does this with a wrapping binary counter, 15 bits wide by default. A second lasts exactly 2^W clock cycles unless a compensation is pending. A pending compensation stretches or shortens one second by an exact number of cycles, which trims the drift of the crystal. A positive value skips counts at the start of the following second. A negative value makes the counter run the top of the current second again, and the update is held back until those extra counts are done.

Software loads a signed 16-bit trim value with a strobe. The value is clamped, held until the next second boundary, used once there, and then cleared. A busy flag marks the closing cycles of each second and any replay in progress. A load strobed while busy is dropped. Deciding how often to trim is left to the surrounding logic.

Top module: `sec_prescaler`

## Requirements
- R1: While `run_en` is high and the count is below 2^W−1, the count rises by exactly one per clock. The second update happens only on the edge that leaves the value 2^W−1.
- R2: With no trim pending, 2^W−1 is followed by 0, and one second spans exactly 2^W enabled clocks (32768 at W=15).
- R3: A pending positive trim N makes the counter jump from 2^W−1 to N, with an update on that edge. The following second therefore lasts 2^W−N clocks.
- R4: A pending negative trim −N, given in two's complement (0xFFFE is −2), sends the counter from 2^W−1 back to 2^W−N with no update. The update fires when 2^W−1 is reached the second time, so the current second lasts 2^W+N clocks.
- R5: A loaded trim acts at exactly one second boundary and is then cleared. The second after it is again 2^W clocks long.
- R6: `busy` is high whenever the count is at or above 2^W−BUSY_LEN (default BUSY_LEN=8), and for the whole of a negative-trim replay. A `comp_load` strobe seen while `busy` is high leaves the pending trim unchanged.
- R7: While `run_en` is low, the count keeps its value and `sec_tick` stays low.
- R8: The trim magnitude is clamped to 2^W−1. Values above +(2^W−1) become +(2^W−1), and values below −(2^W−1), including 0x8000, become −(2^W−1).
- R9: Synchronous active-high reset sets the count to 0 and drives `sec_tick` and `busy` low. It also clears any pending trim and any replay.
- R10: `sec_tick` is high only for the single clock that follows an update edge, while the count already shows the value for the new second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz oscillator clock |
| rst | input | 1 | synchronous active-high reset |
| run_en | input | 1 | counter runs when high, holds when low |
| comp_val | input | 16 | signed trim value, two's complement |
| comp_load | input | 1 | capture strobe for `comp_val` |
| count_o | output | W (15) | present prescaler count |
| sec_tick | output | 1 | one-clock second update pulse |
| busy | output | 1 | second boundary near or replay active; loads ignored |

## Verification
The bound checker enforces on every clock the cycle-local rules:
- the single-step increment;
- that an update follows only from the top count;
- holding while stopped;
- `busy` at the top count;
- suppression of the update at the start of a replay;
- the clamp bound on the stored trim;
- that a strobe during `busy` leaves the trim alone.

Only the bench's scenarios show the whole-second effects: the exact spans of 2^W−N and 2^W+N clocks, the one-shot clearing of a trim, and the clamped trim producing one-clock and near-double seconds. The bench runs the counter at W=8 so that many full seconds fit in the run.

// File: rtl/sec_prescaler_pkg.sv
package sec_prescaler_pkg;

    // Action taken by the counter on the coming clock edge.
    typedef enum logic [2:0] {
        ACT_HOLD   = 3'd0,  // stopped
        ACT_STEP   = 3'd1,  // ordinary increment
        ACT_WRAP   = 3'd2,  // plain boundary, count to zero, pulse
        ACT_SKIP   = 3'd3,  // positive trim, count to N, pulse
        ACT_REPLAY = 3'd4   // negative trim, rewind, no pulse
    } edge_act_t;

    // Decoded effect of an action on counter state.
    typedef struct packed {
        logic load_trim;   // count takes the trim's low bits
        logic to_zero;     // count clears
        logic incr;        // count increments
        logic fire;        // second update
        logic rep_set;     // replay begins
        logic rep_clr;     // replay ends / trim consumed
    } act_fx_t;

    function automatic act_fx_t decode_act(edge_act_t a);
        act_fx_t fx;
        fx = '0;
        case (a)
            ACT_STEP:   fx.incr = 1'b1;
            ACT_WRAP:   begin fx.to_zero = 1'b1; fx.fire = 1'b1; fx.rep_clr = 1'b1; end
            ACT_SKIP:   begin fx.load_trim = 1'b1; fx.fire = 1'b1; fx.rep_clr = 1'b1; end
            ACT_REPLAY: begin fx.load_trim = 1'b1; fx.rep_set = 1'b1; end
            default:    fx = '0;
        endcase
        return fx;
    endfunction

    // Symmetric clamp of a signed value to +/- lim.
    function automatic int clamp_sym(int v, int lim);
        if (v > lim)
            return lim;
        else if (v < -lim)
            return -lim;
        else
            return v;
    endfunction

endpackage

// File: rtl/sp_trim_hold.sv
module sp_trim_hold
    import sec_prescaler_pkg::*;
#(
    parameter int CNT_W  = 15,
    parameter int COMP_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic                     busy,
    input  logic                     consume,
    input  logic [COMP_W-1:0]        val_in,
    output logic signed [COMP_W-1:0] trim_q
);
    localparam int MAG_LIM = (1 << CNT_W) - 1;

    logic signed [COMP_W-1:0] clamped;

    always_comb begin
        clamped = COMP_W'(clamp_sym(int'($signed(val_in)), MAG_LIM));
    end

    always_ff @(posedge clk) begin
        if (rst)
            trim_q <= '0;
        else if (consume)
            trim_q <= '0;
        else if (load && !busy)
            trim_q <= clamped;
    end
endmodule

// File: rtl/sp_edge_decide.sv
module sp_edge_decide
    import sec_prescaler_pkg::*;
#(
    parameter int COMP_W = 16
) (
    input  logic                     run,
    input  logic                     at_top,
    input  logic                     replay_q,
    input  logic signed [COMP_W-1:0] trim,
    output edge_act_t                act
);
    always_comb begin
        if (!run)
            act = ACT_HOLD;
        else if (!at_top)
            act = ACT_STEP;
        else if (replay_q)
            act = ACT_WRAP;
        else if (trim > 0)
            act = ACT_SKIP;
        else if (trim < 0)
            act = ACT_REPLAY;
        else
            act = ACT_WRAP;
    end
endmodule

// File: rtl/sp_count_core.sv
module sp_count_core
    import sec_prescaler_pkg::*;
#(
    parameter int CNT_W    = 15,
    parameter int COMP_W   = 16,
    parameter int BUSY_LEN = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  edge_act_t                act,
    input  logic signed [COMP_W-1:0] trim,
    output logic [CNT_W-1:0]         cnt_q,
    output logic                     replay_q,
    output logic                     tick_q,
    output logic                     at_top,
    output logic                     busy,
    output logic                     consume
);
    localparam int             TOP_I     = (1 << CNT_W) - 1;
    localparam logic [CNT_W-1:0] TOP_VAL   = CNT_W'(TOP_I);
    localparam logic [CNT_W-1:0] BUSY_FROM = CNT_W'(TOP_I - BUSY_LEN + 1);

    act_fx_t fx;

    always_comb begin
        fx      = decode_act(act);
        at_top  = (cnt_q == TOP_VAL);
        busy    = replay_q || (cnt_q >= BUSY_FROM);
        consume = fx.rep_clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            replay_q <= 1'b0;
            tick_q   <= 1'b0;
        end else begin
            tick_q <= fx.fire;
            // The trim's low bits hold N for +N and 2^W-N for -N.
            if (fx.load_trim)
                cnt_q <= trim[CNT_W-1:0];
            else if (fx.to_zero)
                cnt_q <= '0;
            else if (fx.incr)
                cnt_q <= cnt_q + 1'b1;
            if (fx.rep_set)
                replay_q <= 1'b1;
            else if (fx.rep_clr)
                replay_q <= 1'b0;
        end
    end
endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler
    import sec_prescaler_pkg::*;
#(
    parameter int CNT_W    = 15,
    parameter int COMP_W   = 16,
    parameter int BUSY_LEN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [COMP_W-1:0] comp_val,
    input  logic              comp_load,
    output logic [CNT_W-1:0]  count_o,
    output logic              sec_tick,
    output logic              busy
);
    logic signed [COMP_W-1:0] trim_q;
    logic [CNT_W-1:0]         cnt_q;
    logic                     replay_q;
    logic                     tick_q;
    logic                     at_top;
    logic                     busy_w;
    logic                     consume;
    edge_act_t                act;

    sp_trim_hold #(.CNT_W(CNT_W), .COMP_W(COMP_W)) u_trim (
        .clk     (clk),
        .rst     (rst),
        .load    (comp_load),
        .busy    (busy_w),
        .consume (consume),
        .val_in  (comp_val),
        .trim_q  (trim_q)
    );

    sp_edge_decide #(.COMP_W(COMP_W)) u_decide (
        .run      (run_en),
        .at_top   (at_top),
        .replay_q (replay_q),
        .trim     (trim_q),
        .act      (act)
    );

    sp_count_core #(.CNT_W(CNT_W), .COMP_W(COMP_W), .BUSY_LEN(BUSY_LEN)) u_core (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .trim     (trim_q),
        .cnt_q    (cnt_q),
        .replay_q (replay_q),
        .tick_q   (tick_q),
        .at_top   (at_top),
        .busy     (busy_w),
        .consume  (consume)
    );

    assign count_o  = cnt_q;
    assign sec_tick = tick_q;
    assign busy     = busy_w;
endmodule

// File: rtl/sec_prescaler_chk.sv
module sec_prescaler_chk #(
    parameter int CNT_W  = 15,
    parameter int COMP_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     run_en,
    input logic                     comp_load,
    input logic [CNT_W-1:0]         count_o,
    input logic                     sec_tick,
    input logic                     busy,
    input logic signed [COMP_W-1:0] trim_q,
    input logic                     replay_q
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'((1 << CNT_W) - 1);
    localparam int LIM = (1 << CNT_W) - 1;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (run_en && count_o != TOP) |=> (count_o == $past(count_o) + 1'b1)) else $error("step"); // R1

    AST_TICK_FROM_TOP: assert property (@(posedge clk) disable iff (rst)
        $rose(sec_tick) |-> ($past(count_o) == TOP && $past(run_en))) else $error("tick src"); // R10

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (count_o == $past(count_o) && !sec_tick)) else $error("stop"); // R7

    AST_BUSY_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        (count_o == TOP) |-> busy) else $error("busy top"); // R6

    AST_REPLAY_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (run_en && count_o == TOP && !replay_q && trim_q < 0) |=> (!sec_tick && replay_q)) else $error("replay"); // R4

    AST_TRIM_BOUND: assert property (@(posedge clk) disable iff (rst)
        (int'(trim_q) <= LIM && int'(trim_q) >= -LIM)) else $error("clamp"); // R8

    AST_LOAD_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (comp_load && busy && count_o != TOP) |=> (trim_q == $past(trim_q))) else $error("busy load"); // R6
endmodule

bind sec_prescaler sec_prescaler_chk #(.CNT_W(CNT_W), .COMP_W(COMP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .comp_load (comp_load),
    .count_o   (count_o),
    .sec_tick  (sec_tick),
    .busy      (busy),
    .trim_q    (trim_q),
    .replay_q  (replay_q)
);

// File: tb/sec_prescaler_tb.sv
module sec_prescaler_tb;
    localparam int W   = 8;
    localparam int CW  = 16;
    localparam int BL  = 8;
    localparam int SEC = 1 << W;
    localparam int TOP = SEC - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run_en = 1'b0;
    logic [CW-1:0] comp_val = '0;
    logic          comp_load = 1'b0;
    logic [W-1:0]  count_o;
    logic          sec_tick;
    logic          busy;

    int total = 0;
    int bad   = 0;

    // behavioural reference state
    int m_cnt = 0, m_trim = 0;
    bit m_rep = 0, m_tick = 0;

    sec_prescaler #(.CNT_W(W), .COMP_W(CW), .BUSY_LEN(BL)) u_dut (
        .clk(clk), .rst(rst), .run_en(run_en), .comp_val(comp_val),
        .comp_load(comp_load), .count_o(count_o), .sec_tick(sec_tick), .busy(busy)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp(int v);
        if (v > TOP) return TOP;
        if (v < -TOP) return -TOP;
        return v;
    endfunction

    function automatic bit m_busy();
        return m_rep || (m_cnt >= SEC - BL);
    endfunction

    task automatic model_edge();
        bit bz;
        bz = m_busy();
        m_tick = 0;
        if (rst) begin
            m_cnt = 0; m_trim = 0; m_rep = 0;
        end else begin
            if (run_en) begin
                if (m_cnt == TOP) begin
                    if (m_rep) begin
                        m_cnt = 0; m_rep = 0; m_tick = 1; m_trim = 0;
                    end else if (m_trim > 0) begin
                        m_cnt = m_trim; m_tick = 1; m_trim = 0;
                    end else if (m_trim < 0) begin
                        m_cnt = SEC + m_trim; m_rep = 1;
                    end else begin
                        m_cnt = 0; m_tick = 1;
                    end
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (comp_load && !bz)
                m_trim = clamp(int'($signed(comp_val)));
        end
    endtask

    // One clock: model follows the edge, outputs compared mid-cycle.
    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R1 count", int'(count_o), m_cnt);
        check("R10 tick", int'(sec_tick), int'(m_tick));
        check("R6 busy", int'(busy), int'(m_busy()));
    endtask

    task automatic sec_len(output int n);
        n = 0;
        do begin
            cyc();
            n++;
        end while (!sec_tick && n < 4 * SEC);
    endtask

    task automatic load_pulse(input logic [CW-1:0] v);
        comp_val  = v;
        comp_load = 1'b1;
        cyc();
        comp_load = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int held;
        @(negedge clk);
        repeat (3) cyc();
        // R9: reset state
        check("R9 count", int'(count_o), 0);
        check("R9 tick", int'(sec_tick), 0);
        check("R9 busy", int'(busy), 0);
        rst = 1'b0;
        run_en = 1'b1;

        sec_len(n); check("R2 first second", n, SEC);
        cyc();
        check("R10 single pulse", int'(sec_tick), 0);
        check("R10 new count", int'(count_o), 1);
        sec_len(n); check("R2 plain second", n + 1, SEC);

        // R3: +2 shortens the following second
        load_pulse(16'd2); sec_len(n); check("R3 current unchanged", n + 1, SEC);
        check("R3 jump target", int'(count_o), 2);
        sec_len(n); check("R3 short second", n, SEC - 2);
        sec_len(n); check("R5 cleared after skip", n, SEC);

        // R4: -2 lengthens the current second
        load_pulse(16'hFFFE); sec_len(n); check("R4 long second", n + 1, SEC + 2);
        sec_len(n); check("R5 cleared after replay", n, SEC);

        // R6: load during busy is dropped
        n = 0;
        while (!busy) begin cyc(); n++; end
        load_pulse(16'd5); n++;
        sec_len(held); check("R6 busy load ignored", n + held, SEC);
        sec_len(n); check("R6 next second plain", n, SEC);

        // R8: clamp positive and negative
        load_pulse(16'd1000); sec_len(n); check("R8 pos current", n + 1, SEC);
        sec_len(n); check("R8 pos clamp one-clock second", n, 1);
        sec_len(n); check("R8 after pos clamp", n, SEC);
        load_pulse(16'h8000); sec_len(n); check("R8 neg clamp long second", n + 1, 2 * SEC - 1);

        // R7: stop holds count, no pulse
        repeat (10) cyc();
        run_en = 1'b0;
        cyc();
        held = int'(count_o);
        n = 0;
        repeat (40) begin
            cyc();
            if (sec_tick || int'(count_o) != held) n++;
        end
        check("R7 hold while stopped", n, 0);
        run_en = 1'b1;
        cyc();
        check("R7 resumes", int'(count_o), held + 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule